// File: doc/BRIEF.md
# Recorded-Miss List Prefetcher

This block holds one prefetch engine per hardware thread. Each engine learns the order of cache-line misses its thread takes inside a code region that software brackets with start and stop commands. The first pass after a fresh start is a learning pass. The engine appends every observed miss line to an on-chip list and issues nothing. On every later pass it plays the list back as line prefetches, and it keeps a bounded distance ahead of the point where the thread's live misses currently stand.

The live miss stream rarely matches the recording exactly. Each live miss is compared against a small window of upcoming list entries. A hit moves the matched position past any entries the thread skipped. A miss that hits nothing in the window is treated as an extra miss and does not stall playback. During a replay pass, every live miss is written into a second list buffer. At stop, that buffer becomes the active list, so the next pass replays what the thread actually did.

The miss input carries no back-pressure: at most one miss per thread per cycle, and each one is consumed in the cycle it is presented. The prefetch output is a valid/ready stream per thread. Once valid is raised, valid and the address are held until ready is seen, unless a stop command ends the pass. At most one prefetch per thread transfers per cycle. Start, fresh and stop are plain per-thread pulses.

Top module: `lpf_cluster`

## Requirements
- R1: Each of the NUM_THR (4) threads has its own engine, list and pointers. Commands, misses and ready on one thread never change another thread's prefetch output or list.
- R2: A start pulse while idle begins a pass. The pass is a learning pass if fresh is 1 or no list exists yet, and a replay pass otherwise. A start while a pass is active is ignored. A stop while idle is ignored. Misses while idle are ignored. A stop ends the pass, after which pf_valid is 0. After reset every pf_valid is 0.
- R3: During a learning pass, each miss line is appended to the list in arrival order, and pf_valid stays 0.
- R4: Lines are 128 bytes. Miss address bits [6:0] are discarded, and pf_addr bits [6:0] are always 0.
- R5: A replay pass issues list entries in list order, starting from entry 0. Each entry is issued once per pass.
- R6: Entry i is offered only while i < matched + PF_DIST (default 8), where matched is the count of list entries consumed by live misses so far. With no live misses, exactly the first 8 entries are issued.
- R7: While pf_valid is 1 and pf_ready is 0, pf_valid and pf_addr hold in the next cycle unless stop is pulsed.
- R8: A live miss equal to one of the next WIN (default 4) unconsumed entries, at offset k from the matched position, advances matched by k+1. This skips the entries in between.
- R9: A live miss that matches none of the next WIN entries leaves matched unchanged, and playback continues with later misses.
- R10: After a replay pass, the list used on the next pass is exactly the sequence of live misses seen during that pass, in order.
- R11: A learning pass keeps at most DEPTH (default 256) entries. Misses beyond that are dropped, and the first DEPTH entries are kept.
- R12: A miss presented in the same cycle as stop is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | NUM_THR | Per-thread pass start pulse |
| cmd_fresh | input | NUM_THR | With start: force a learning pass |
| cmd_stop | input | NUM_THR | Per-thread pass end pulse |
| miss_valid | input | NUM_THR | Per-thread miss observed this cycle |
| miss_addr | input | NUM_THR*AW | Miss byte address, thread t in bits [t*AW +: AW] |
| pf_ready | input | NUM_THR | Prefetch consumer accepts this cycle |
| pf_valid | output | NUM_THR | Prefetch request offered |
| pf_addr | output | NUM_THR*AW | Line-aligned prefetch address, thread t in bits [t*AW +: AW] |

## Verification
Replay is driven with four miss patterns:
- A live stream identical to the recording shows the in-order playback and the unchanged rewritten list.
- A pass with no misses at all exposes the issue distance as a hard count of eight.
- A miss three entries ahead, set against one four entries ahead, separates a window hit (further prefetches released) from a window miss (none released).
- An inserted foreign line followed by resumed matches shows that playback continues and that the next pass replays exactly the live sequence.

Back-pressure, overflow past the list depth, command misuse and a second thread running alone each isolate one further rule.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef enum logic [1:0] {
    LPF_IDLE   = 2'd0,
    LPF_RECORD = 2'd1,
    LPF_REPLAY = 2'd2
  } lpf_mode_e;

  // byte offset bits inside one 128-byte line
  localparam int LINE_OFS = 7;
endpackage

// File: rtl/lpf_list_store.sv
module lpf_list_store #(
  parameter int LW    = 33,
  parameter int DEPTH = 256,
  parameter int NRD   = 5,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     wr_buf,
  input  logic [IW-1:0]            wr_idx,
  input  logic [LW-1:0]            wr_line,
  input  logic                     rd_buf,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][LW-1:0]   rd_line
);
  // two banks: one is played back, the other collects the rewritten list
  logic [LW-1:0] mem_q [2][DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_buf][wr_idx] <= wr_line;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_line[g] = mem_q[rd_buf][rd_idx[g]];
  end
endmodule

// File: rtl/lpf_resync.sv
module lpf_resync #(
  parameter int LW  = 33,
  parameter int WIN = 4,
  localparam int SW = $clog2(WIN + 1)
) (
  input  logic [LW-1:0]           miss_line,
  input  logic [WIN-1:0][LW-1:0]  win_line,
  input  logic [WIN-1:0]          win_ok,
  output logic                    hit,
  output logic [SW-1:0]           step
);
  // nearest matching entry wins
  always_comb begin
    hit  = 1'b0;
    step = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (win_ok[k] && (win_line[k] == miss_line)) begin
        hit  = 1'b1;
        step = SW'(k + 1);
      end
    end
  end
endmodule

// File: rtl/lpf_issue.sv
module lpf_issue #(
  parameter int LW   = 33,
  parameter int CW   = 9,
  parameter int DIST = 8,
  parameter int OFS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              clear,
  input  logic              abort,
  input  logic [CW-1:0]     match_pos,
  input  logic [CW-1:0]     list_len,
  input  logic [LW-1:0]     rd_line,
  output logic [CW-1:0]     issue_pos,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [LW+OFS-1:0] pf_addr
);
  localparam logic [CW:0] DIST_W = (CW + 1)'(DIST);

  logic [CW-1:0] issue_q;
  logic [CW:0]   limit;

  assign limit     = {1'b0, match_pos} + DIST_W;
  assign pf_valid  = active && (issue_q < list_len) && ({1'b0, issue_q} < limit);
  assign pf_addr   = {rd_line, {OFS{1'b0}}};
  assign issue_pos = issue_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    issue_q <= '0;
    else if (clear)                issue_q <= '0;
    else if (pf_valid && pf_ready) issue_q <= issue_q + 1'b1;
  end

  // R7: an offered request is held until taken
  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !abort) |=> (pf_valid && $stable(pf_addr)));

  // R5: playback never runs past the end of the list
  assert_issue_in_list_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (issue_q <= list_len));
endmodule

// File: rtl/lpf_engine.sv
module lpf_engine
  import lpf_pkg::*;
#(
  parameter int AW    = 40,
  parameter int DEPTH = 256,
  parameter int DIST  = 8,
  parameter int WIN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_fresh,
  input  logic          cmd_stop,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  input  logic          pf_ready,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr
);
  localparam int LW  = AW - LINE_OFS;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);
  localparam int SW  = $clog2(WIN + 1);
  localparam int NRD = WIN + 1;
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);

  lpf_mode_e     state_q;
  logic          sel_q;
  logic          have_q;
  logic [CW-1:0] act_len_q;
  logic [CW-1:0] wr_cnt_q;
  logic [CW-1:0] match_q;

  logic [LW-1:0]           miss_line;
  logic                    miss_take;
  logic                    wr_en;
  logic                    wr_buf;
  logic [NRD-1:0][IW-1:0]  rd_idx;
  logic [NRD-1:0][LW-1:0]  rd_line;
  logic [WIN-1:0][LW-1:0]  win_line;
  logic [WIN-1:0]          win_ok;
  logic                    hit;
  logic [SW-1:0]           step;
  logic [CW-1:0]           issue_pos;
  logic                    replaying;
  logic                    pass_begin;

  assign miss_line  = miss_addr[AW-1:LINE_OFS];
  assign miss_take  = miss_valid && !cmd_stop && (state_q != LPF_IDLE);
  assign wr_en      = miss_take && (wr_cnt_q < DEPTH_W);
  assign replaying  = (state_q == LPF_REPLAY);
  assign wr_buf     = replaying ? ~sel_q : sel_q;
  assign pass_begin = (state_q == LPF_IDLE) && cmd_start;

  assign rd_idx[0] = issue_pos[IW-1:0];
  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [CW:0] pos;
    assign pos           = {1'b0, match_q} + (CW + 1)'(k);
    assign win_ok[k]     = pos < {1'b0, act_len_q};
    assign rd_idx[k + 1] = pos[IW-1:0];
    assign win_line[k]   = rd_line[k + 1];
  end

  lpf_list_store #(.LW(LW), .DEPTH(DEPTH), .NRD(NRD)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_buf  (wr_buf),
    .wr_idx  (wr_cnt_q[IW-1:0]),
    .wr_line (miss_line),
    .rd_buf  (sel_q),
    .rd_idx  (rd_idx),
    .rd_line (rd_line)
  );

  lpf_resync #(.LW(LW), .WIN(WIN)) u_resync (
    .miss_line (miss_line),
    .win_line  (win_line),
    .win_ok    (win_ok),
    .hit       (hit),
    .step      (step)
  );

  lpf_issue #(.LW(LW), .CW(CW), .DIST(DIST), .OFS(LINE_OFS)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (replaying),
    .clear     (pass_begin),
    .abort     (cmd_stop),
    .match_pos (match_q),
    .list_len  (act_len_q),
    .rd_line   (rd_line[0]),
    .issue_pos (issue_pos),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LPF_IDLE;
      sel_q     <= 1'b0;
      have_q    <= 1'b0;
      act_len_q <= '0;
      wr_cnt_q  <= '0;
      match_q   <= '0;
    end else begin
      case (state_q)
        LPF_IDLE: begin
          if (cmd_start) begin
            state_q  <= (cmd_fresh || !have_q) ? LPF_RECORD : LPF_REPLAY;
            wr_cnt_q <= '0;
            match_q  <= '0;
          end
        end
        LPF_RECORD: begin
          if (cmd_stop) begin
            state_q   <= LPF_IDLE;
            act_len_q <= wr_cnt_q;
            have_q    <= 1'b1;
          end else if (wr_en) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
          end
        end
        LPF_REPLAY: begin
          if (cmd_stop) begin
            state_q   <= LPF_IDLE;
            act_len_q <= wr_cnt_q;
            sel_q     <= ~sel_q;
          end else begin
            if (wr_en) wr_cnt_q <= wr_cnt_q + 1'b1;
            if (miss_take && hit) match_q <= match_q + CW'(step);
          end
        end
        default: state_q <= LPF_IDLE;
      endcase
    end
  end

  // R2: nothing is offered outside a pass
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPF_IDLE) |-> !pf_valid);

  // R3: a learning pass never offers prefetches
  assert_learn_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPF_RECORD) |-> !pf_valid);

  // R11: the write count never passes the list depth
  assert_list_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_q <= DEPTH_W);

  // R8: one miss moves the matched position by at most the window size
  assert_window_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (replaying && !cmd_stop) |=> ((match_q - $past(match_q)) <= CW'(WIN)));
endmodule

// File: rtl/lpf_cluster.sv
module lpf_cluster #(
  parameter int NUM_THR = 4,
  parameter int AW      = 40,
  parameter int DEPTH   = 256,
  parameter int PF_DIST = 8,
  parameter int WIN     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THR-1:0]     cmd_start,
  input  logic [NUM_THR-1:0]     cmd_fresh,
  input  logic [NUM_THR-1:0]     cmd_stop,
  input  logic [NUM_THR-1:0]     miss_valid,
  input  logic [NUM_THR*AW-1:0]  miss_addr,
  input  logic [NUM_THR-1:0]     pf_ready,
  output logic [NUM_THR-1:0]     pf_valid,
  output logic [NUM_THR*AW-1:0]  pf_addr
);
  // R1: one fully separate engine per hardware thread
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    lpf_engine #(.AW(AW), .DEPTH(DEPTH), .DIST(PF_DIST), .WIN(WIN)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start[t]),
      .cmd_fresh  (cmd_fresh[t]),
      .cmd_stop   (cmd_stop[t]),
      .miss_valid (miss_valid[t]),
      .miss_addr  (miss_addr[t*AW +: AW]),
      .pf_ready   (pf_ready[t]),
      .pf_valid   (pf_valid[t]),
      .pf_addr    (pf_addr[t*AW +: AW])
    );
  end
endmodule

// File: tb/test_lpf_cluster.sv
`timescale 1ns/1ps
module test_lpf_cluster;
  localparam int NT = 4;
  localparam int AW = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   cmd_start = '0, cmd_fresh = '0, cmd_stop = '0;
  logic [NT-1:0]   miss_valid = '0, pf_ready = '1, pf_valid;
  logic [NT*AW-1:0] miss_addr = '0, pf_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int got [300];
  int got_n;
  int exp_l [300];
  int exp_n;
  bit lo_bad;
  bit others_busy;

  always #2 clk = ~clk;

  lpf_cluster i_lpf_cluster (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_fresh(cmd_fresh),
    .cmd_stop(cmd_stop), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pf_line(input int t);
    logic [AW-1:0] a;
    a = pf_addr[t*AW +: AW];
    return int'(a >> 7);
  endfunction

  // one cycle on thread t: optional miss, collect any accepted prefetch
  task automatic step(input int t, input bit m, input int line);
    logic [AW-1:0] a;
    a = (AW'(line) << 7) | AW'((line * 37 + 5) & 127);
    miss_valid[t] = m;
    miss_addr[t*AW +: AW] = a;
    for (int u = 0; u < NT; u++)
      if (u != t && pf_valid[u]) others_busy = 1;
    if (pf_valid[t] && pf_ready[t]) begin
      if (pf_addr[t*AW +: 7] != 7'd0) lo_bad = 1;
      got[got_n] = pf_line(t);
      got_n++;
    end
    tick();
    miss_valid[t] = 1'b0;
  endtask

  task automatic start_pass(input int t, input bit fresh);
    cmd_start[t] = 1'b1; cmd_fresh[t] = fresh;
    tick();
    cmd_start[t] = 1'b0; cmd_fresh[t] = 1'b0;
    got_n = 0;
  endtask

  task automatic stop_pass(input int t);
    cmd_stop[t] = 1'b1;
    tick();
    cmd_stop[t] = 1'b0;
  endtask

  // learning pass of n consecutive lines from base
  task automatic learn(input int t, input int base, input int n, input string req);
    bit loud = 0;
    start_pass(t, 1'b1);
    for (int i = 0; i < n; i++) begin
      if (pf_valid[t]) loud = 1;
      step(t, 1'b1, base + i);
    end
    stop_pass(t);
    chk(!loud, req, loud, 0);
  endtask

  task automatic compare_got(input string req);
    int bad = 0;
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] != exp_l[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // replay pass feeding the given lines as live misses, expect them back
  task automatic replay_same(input int t, input int base, input int n, input string req);
    start_pass(t, 1'b0);
    for (int i = 0; i < n; i++) step(t, 1'b1, base + i);
    for (int i = 0; i < 12; i++) step(t, 1'b0, 0);
    stop_pass(t);
    exp_n = n;
    for (int i = 0; i < n; i++) exp_l[i] = base + i;
    compare_got(req);
  endtask

  task automatic sc_reset();
    tick();
    chk(pf_valid == '0, "R2 reset quiet", pf_valid, 0);
  endtask

  task automatic sc_record();
    learn(0, 100, 10, "R3 learn silent");
    // reopen as learning pass to add a miss alongside stop
    start_pass(0, 1'b1);
    for (int i = 0; i < 10; i++) step(0, 1'b1, 100 + i);
    cmd_stop[0] = 1'b1;
    step(0, 1'b1, 555);
    cmd_stop[0] = 1'b0;
    lo_bad = 0;
    replay_same(0, 100, 10, "R5 R10 R12 in-order replay");
    chk(!lo_bad, "R4 line aligned", lo_bad, 0);
  endtask

  task automatic sc_distance();
    learn(0, 100, 10, "R3 learn silent");
    start_pass(0, 1'b0);
    for (int i = 0; i < 20; i++) step(0, 1'b0, 0);
    chk(got_n == 8, "R6 distance count", got_n, 8);
    chk(got[7] == 107, "R6 last ahead", got[7], 107);
    step(0, 1'b1, 103);
    for (int i = 0; i < 12; i++) step(0, 1'b0, 0);
    chk(got_n == 10, "R8 window hit releases", got_n, 10);
    chk(got[9] == 109, "R8 tail entry", got[9], 109);
    stop_pass(0);
  endtask

  task automatic sc_insert();
    learn(0, 100, 10, "R3 learn silent");
    start_pass(0, 1'b0);
    for (int i = 0; i < 20; i++) step(0, 1'b0, 0);
    step(0, 1'b1, 104);
    for (int i = 0; i < 10; i++) step(0, 1'b0, 0);
    chk(got_n == 8, "R9 beyond window no advance", got_n, 8);
    step(0, 1'b1, 100);
    for (int i = 0; i < 10; i++) step(0, 1'b0, 0);
    chk(got_n == 9 && got[8] == 108, "R9 playback continues", got[8], 108);
    step(0, 1'b1, 500);
    step(0, 1'b1, 101);
    for (int i = 0; i < 10; i++) step(0, 1'b0, 0);
    chk(got_n == 10, "R9 after extra miss", got_n, 10);
    stop_pass(0);
    start_pass(0, 1'b0);
    step(0, 1'b1, 104); step(0, 1'b1, 100); step(0, 1'b1, 500); step(0, 1'b1, 101);
    for (int i = 0; i < 12; i++) step(0, 1'b0, 0);
    stop_pass(0);
    exp_n = 4;
    exp_l[0] = 104; exp_l[1] = 100; exp_l[2] = 500; exp_l[3] = 101;
    compare_got("R10 rewritten list");
  endtask

  task automatic sc_backpressure();
    bit held = 1;
    learn(0, 100, 5, "R3 learn silent");
    pf_ready[0] = 1'b0;
    start_pass(0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      if (!pf_valid[0] || pf_line(0) != 100) held = 0;
      tick();
    end
    chk(held, "R7 held under backpressure", held, 1);
    pf_ready[0] = 1'b1;
    tick();
    pf_ready[0] = 1'b0;
    chk(pf_valid[0] && pf_line(0) == 101, "R7 advance after accept", pf_line(0), 101);
    stop_pass(0);
    chk(!pf_valid[0], "R2 stop drops offer", pf_valid[0], 0);
    pf_ready[0] = 1'b1;
  endtask

  task automatic sc_overflow();
    learn(0, 1000, 260, "R3 learn silent");
    replay_same(0, 1000, 256, "R11 first DEPTH kept");
  endtask

  task automatic sc_commands();
    learn(3, 400, 5, "R3 learn silent");
    for (int i = 0; i < 3; i++) step(3, 1'b1, 900 + i);
    stop_pass(3);
    chk(!pf_valid[3], "R2 idle stop ignored", pf_valid[3], 0);
    start_pass(3, 1'b0);
    for (int i = 0; i < 3; i++) step(3, 1'b0, 0);
    cmd_start[3] = 1'b1;
    step(3, 1'b0, 0);
    cmd_start[3] = 1'b0;
    for (int i = 0; i < 10; i++) step(3, 1'b0, 0);
    stop_pass(3);
    exp_n = 5;
    for (int i = 0; i < 5; i++) exp_l[i] = 400 + i;
    compare_got("R2 start in pass ignored, idle misses ignored");
    learn(3, 700, 2, "R3 learn silent");
    replay_same(3, 700, 2, "R2 fresh relearn");
  endtask

  task automatic sc_threads();
    learn(1, 200, 10, "R3 learn silent");
    learn(2, 300, 3, "R3 learn silent");
    others_busy = 0;
    start_pass(1, 1'b0);
    for (int i = 0; i < 14; i++) step(1, 1'b0, 0);
    stop_pass(1);
    chk(!others_busy, "R1 other threads quiet", others_busy, 0);
    chk(got_n == 8 && got[0] == 200, "R1 own list thread1", got[0], 200);
    replay_same(2, 300, 3, "R1 own list thread2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sc_reset();
    sc_record();
    sc_distance();
    sc_insert();
    sc_backpressure();
    sc_overflow();
    sc_commands();
    sc_threads();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule